// File: doc/BRIEF.md
# Jump Outcome Resolver

This block settles the control-flow result of one branch instruction for a virtual machine with 64-bit registers. It takes the 8-bit opcode, the signed 16-bit slot offset, the 32-bit immediate, the address of the current instruction and the two register operands. From these it works out whether the branch is taken and which instruction runs next. It also says whether the instruction is a function call, with the call number, or a program exit, and it flags encodings that are not legal branches. The opcode splits into three fields. Bits [2:0] give the class: 0x5 compares full 64-bit values and 0x6 compares only the low 32 bits. Bit [3] selects the right operand: 1 takes the second register, 0 takes the sign-extended immediate. Bits [7:4] give the operation code.

Instructions come in on a valid/ready stream, and each result leaves on a second valid/ready stream after one register stage. An instruction is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new instruction is accepted. Program addresses count 64-bit instruction slots. A taken branch goes to the instruction after the current one plus the sign-extended offset, and the sum wraps at the address width.

Top module: `jump_resolver`

## Requirements
- R1: An instruction accepted in a cycle (`in_valid` and `in_ready` high) appears on the outputs with `out_valid` high from the next clock edge; `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, every output field stays unchanged and `in_ready` is low.
- R3: During and after reset, `out_valid` is low and `in_ready` is high.
- R4: Code 0x1 is taken when the operands are equal, and code 0x5 is taken when they differ.
- R5: Codes 0x2 (greater), 0x3 (greater or equal), 0xa (less) and 0xb (less or equal) compare the operands as unsigned numbers.
- R6: Codes 0x6 (greater), 0x7 (greater or equal), 0xc (less) and 0xd (less or equal) compare the operands as two's-complement numbers.
- R7: Code 0x4 is taken when the bitwise AND of the operands is nonzero.
- R8: In class 0x6 only bits [31:0] of both operands are compared, and bit 31 is the sign; in class 0x5 all 64 bits are compared.
- R9: With opcode bit 3 clear, the immediate is sign-extended to 64 bits and used as the right operand in place of the second register.
- R10: A taken branch gives `out_next_pc` = pc + 1 + sign-extended offset, modulo 2^PC_W. Every other outcome gives pc + 1.
- R11: Opcode 0x05 (code 0x0 in class 0x5) is always taken.
- R12: Code 0x8 in either class sets `out_call`, drives the immediate onto `out_call_id`, and is not taken. `out_call_id` is zero for every other instruction.
- R13: Code 0x9 in class 0x5 sets `out_exit` and is not taken.
- R14: Codes 0x0 and 0x9 in class 0x6, codes 0xe and 0xf, and any class other than 0x5 or 0x6 set `out_illegal` and clear taken, call and exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present on the input fields |
| in_ready | output | 1 | Resolver can accept an instruction |
| in_opcode | input | 8 | Operation code [7:4], operand select [3], class [2:0] |
| in_offset | input | 16 | Signed branch offset in instruction slots |
| in_imm | input | 32 | Immediate operand or call number |
| in_pc | input | PC_W | Slot address of the current instruction |
| in_dst | input | 64 | Left operand register value |
| in_src | input | 64 | Right operand register value |
| out_valid | output | 1 | Result present on the output fields |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | PC_W | Slot address of the next instruction |
| out_call | output | 1 | Instruction is a function call |
| out_exit | output | 1 | Instruction is a program exit |
| out_illegal | output | 1 | Encoding is not a legal branch |
| out_call_id | output | 32 | Call number, zero unless `out_call` |

## Verification
Each comparison code gets operand pairs that the nearby codes resolve differently. An all-ones value against one separates the unsigned codes from the signed ones. Equal values separate the strict forms from the inclusive ones, and the most negative value is compared against zero and against the most positive value. A value with only bit 31 set is run through both classes, and so are operands that agree only in their low word; this exposes any leak of the upper half, or a wrong choice of sign bit, in the 32-bit class. Immediate-source cases place -1 in the immediate, which tells sign extension apart from zero extension. Offsets at +32767, -32768 and small negative values probe the wrap of the target adder, and a stalled consumer shows whether results are held.

// File: rtl/jres_pkg.sv
package jres_pkg;
  // Opcode class values that carry branch semantics
  localparam logic [2:0] CLS_WIDE   = 3'h5;
  localparam logic [2:0] CLS_NARROW = 3'h6;

  // Operation codes found in opcode bits [7:4]
  localparam logic [3:0] OP_ALWAYS = 4'h0;
  localparam logic [3:0] OP_EQ     = 4'h1;
  localparam logic [3:0] OP_UGT    = 4'h2;
  localparam logic [3:0] OP_UGE    = 4'h3;
  localparam logic [3:0] OP_BITS   = 4'h4;
  localparam logic [3:0] OP_NE     = 4'h5;
  localparam logic [3:0] OP_SGT    = 4'h6;
  localparam logic [3:0] OP_SGE    = 4'h7;
  localparam logic [3:0] OP_CALL   = 4'h8;
  localparam logic [3:0] OP_LEAVE  = 4'h9;
  localparam logic [3:0] OP_ULT    = 4'ha;
  localparam logic [3:0] OP_ULE    = 4'hb;
  localparam logic [3:0] OP_SLT    = 4'hc;
  localparam logic [3:0] OP_SLE    = 4'hd;

  // Raw relations between left and right operand
  typedef struct packed {
    logic eq;
    logic ult;
    logic slt;
    logic any;
  } cmp_flags_t;

  // Control-flow outcome
  typedef struct packed {
    logic taken;
    logic call;
    logic leave;
    logic bad;
  } verdict_t;
endpackage

// File: rtl/jres_decode.sv
module jres_decode
  import jres_pkg::*;
(
  input  logic [7:0] opcode,
  output logic [3:0] code,
  output logic       narrow,
  output logic       use_imm,
  output logic       legal
);
  logic [2:0] cls;
  logic       is_branch_cls;
  logic       wide_only;

  always_comb begin
    cls           = opcode[2:0];
    code          = opcode[7:4];
    use_imm       = ~opcode[3];
    narrow        = (cls == CLS_NARROW);
    is_branch_cls = (cls == CLS_WIDE) || (cls == CLS_NARROW);
    // unconditional jump and exit exist only in the 64-bit class
    wide_only     = (code == OP_ALWAYS) || (code == OP_LEAVE);
    legal         = is_branch_cls && (code <= OP_SLE) && !(narrow && wide_only);
  end
endmodule

// File: rtl/jres_compare.sv
module jres_compare
  import jres_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output cmp_flags_t   flags
);
  always_comb begin
    flags.eq  = (lhs == rhs);
    flags.ult = (lhs < rhs);
    flags.slt = ($signed(lhs) < $signed(rhs));
    flags.any = |(lhs & rhs);
  end
endmodule

// File: rtl/jres_condition.sv
module jres_condition
  import jres_pkg::*;
(
  input  logic [3:0]  code,
  input  logic        legal,
  input  cmp_flags_t  flags,
  output verdict_t    verdict
);
  logic hit;

  always_comb begin
    unique case (code)
      OP_ALWAYS: hit = 1'b1;
      OP_EQ:     hit = flags.eq;
      OP_NE:     hit = ~flags.eq;
      OP_UGT:    hit = ~(flags.ult | flags.eq);
      OP_UGE:    hit = ~flags.ult;
      OP_ULT:    hit = flags.ult;
      OP_ULE:    hit = flags.ult | flags.eq;
      OP_SGT:    hit = ~(flags.slt | flags.eq);
      OP_SGE:    hit = ~flags.slt;
      OP_SLT:    hit = flags.slt;
      OP_SLE:    hit = flags.slt | flags.eq;
      OP_BITS:   hit = flags.any;
      default:   hit = 1'b0;
    endcase
    verdict.bad   = ~legal;
    verdict.call  = legal && (code == OP_CALL);
    verdict.leave = legal && (code == OP_LEAVE);
    verdict.taken = legal && hit;
  end
endmodule

// File: rtl/jres_target.sv
module jres_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  input  logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  // PC_W is expected to exceed OFF_W
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] off_ext;

  always_comb begin
    seq_pc  = pc + PC_W'(1);
    off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    next_pc = taken ? (seq_pc + off_ext) : seq_pc;
  end
endmodule

// File: rtl/jres_out_stage.sv
module jres_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign up_ready = ~full_q | dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
  import jres_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32,
  parameter int PC_W   = 32,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode,
  input  logic [OFF_W-1:0] in_offset,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [XLEN-1:0]  in_dst,
  input  logic [XLEN-1:0]  in_src,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_taken,
  output logic [PC_W-1:0]  out_next_pc,
  output logic             out_call,
  output logic             out_exit,
  output logic             out_illegal,
  output logic [IMM_W-1:0] out_call_id
);
  localparam int NUM_W  = 2;
  localparam int IEXT_W = XLEN - IMM_W;
  localparam int PAY_W  = $bits(verdict_t) + PC_W + IMM_W;

  logic [3:0]      code;
  logic            narrow;
  logic            use_imm;
  logic            legal;
  logic [XLEN-1:0] rhs;
  cmp_flags_t      flags_by_w [NUM_W];
  cmp_flags_t      flags;
  verdict_t        verdict;
  logic [PC_W-1:0] next_pc;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;
  verdict_t        v_out;

  jres_decode u_decode (
    .opcode  (in_opcode),
    .code    (code),
    .narrow  (narrow),
    .use_imm (use_imm),
    .legal   (legal)
  );

  assign rhs = use_imm ? {{IEXT_W{in_imm[IMM_W-1]}}, in_imm} : in_src;

  // one comparator per operand width: index 0 full width, index 1 low word
  for (genvar g = 0; g < NUM_W; g++) begin : g_cmp
    localparam int CW = (g == 0) ? XLEN : NARROW;
    jres_compare #(.W(CW)) u_cmp (
      .lhs   (in_dst[CW-1:0]),
      .rhs   (rhs[CW-1:0]),
      .flags (flags_by_w[g])
    );
  end

  assign flags = narrow ? flags_by_w[1] : flags_by_w[0];

  jres_condition u_cond (
    .code    (code),
    .legal   (legal),
    .flags   (flags),
    .verdict (verdict)
  );

  jres_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .pc      (in_pc),
    .offset  (in_offset),
    .taken   (verdict.taken),
    .next_pc (next_pc)
  );

  assign pay_in = {verdict, next_pc, (verdict.call ? in_imm : {IMM_W{1'b0}})};

  jres_out_stage #(.DATA_W(PAY_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign v_out       = pay_out[PAY_W-1 -: $bits(verdict_t)];
  assign out_next_pc = pay_out[IMM_W +: PC_W];
  assign out_call_id = pay_out[IMM_W-1:0];
  assign out_taken   = v_out.taken;
  assign out_call    = v_out.call;
  assign out_exit    = v_out.leave;
  assign out_illegal = v_out.bad;
endmodule

// File: rtl/jres_checker.sv
module jres_checker #(
  parameter int PC_W  = 32,
  parameter int IMM_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_opcode,
  input logic [IMM_W-1:0] in_imm,
  input logic [PC_W-1:0]  in_pc,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_taken,
  input logic [PC_W-1:0]  out_next_pc,
  input logic             out_call,
  input logic             out_exit,
  input logic             out_illegal,
  input logic [IMM_W-1:0] out_call_id
);
  // R1
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_taken) && $stable(out_next_pc)
      && $stable(out_call) && $stable(out_exit) && $stable(out_illegal) && $stable(out_call_id));

  // R10
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_taken || (out_next_pc == $past(in_pc) + PC_W'(1)));

  // R11
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode == 8'h05 |=> out_taken);

  // R12
  call_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode[7:4] == 4'h8 && in_opcode[2:0] == 3'h5
      |=> out_call && out_call_id == $past(in_imm));

  // R13
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_taken, out_call, out_exit, out_illegal}));

  // R14
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode[2:0] == 3'h6 && in_opcode[7:4] == 4'h9
      |=> out_illegal && !out_exit);
endmodule

bind jump_resolver jres_checker #(.PC_W(PC_W), .IMM_W(IMM_W)) u_jres_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_opcode   (in_opcode),
  .in_imm      (in_imm),
  .in_pc       (in_pc),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_taken   (out_taken),
  .out_next_pc (out_next_pc),
  .out_call    (out_call),
  .out_exit    (out_exit),
  .out_illegal (out_illegal),
  .out_call_id (out_call_id)
);

// File: tb/test_jump_resolver.sv
module test_jump_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [15:0] in_offset = '0;
  logic [31:0] in_imm = '0;
  logic [31:0] in_pc = '0;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken;
  logic [31:0] out_next_pc;
  logic        out_call;
  logic        out_exit;
  logic        out_illegal;
  logic [31:0] out_call_id;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  jump_resolver i_jump_resolver (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_offset(in_offset), .in_imm(in_imm),
    .in_pc(in_pc), .in_dst(in_dst), .in_src(in_src),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_next_pc(out_next_pc),
    .out_call(out_call), .out_exit(out_exit),
    .out_illegal(out_illegal), .out_call_id(out_call_id)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] off;
    logic [31:0] imm;
    logic [31:0] pc;
    logic [63:0] dst;
    logic [63:0] src;
    logic        tk;
    logic [31:0] npc;
    logic        cl;
    logic        ex;
    logic        il;
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXS = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam int NV = 31;

  localparam vec_t VECS [NV] = '{
    '{8'h1D, 16'd5, 32'd0, 32'd100, 64'd5, 64'd5, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 eq
    '{8'h1D, 16'd5, 32'd0, 32'd100, 64'd5, 64'd6, 1'b0, 32'd101, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 eq miss
    '{8'h5D, 16'd5, 32'd0, 32'd100, 64'd5, 64'd6, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 ne
    '{8'h2D, 16'd5, 32'd0, 32'd100, ONES, 64'd1, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd5},   // R5 ugt
    '{8'h6D, 16'd5, 32'd0, 32'd100, ONES, 64'd1, 1'b0, 32'd101, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 sgt
    '{8'hAD, 16'd5, 32'd0, 32'd100, 64'd1, ONES, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd5},   // R5 ult
    '{8'hCD, 16'd5, 32'd0, 32'd100, ONES, 64'd1, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 slt
    '{8'h3D, 16'd5, 32'd0, 32'd100, 64'd7, 64'd7, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 uge equal
    '{8'hBD, 16'd5, 32'd0, 32'd100, 64'd8, 64'd7, 1'b0, 32'd101, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 ule
    '{8'h7D, 16'd5, 32'd0, 32'd100, MINS, 64'd0, 1'b0, 32'd101, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 sge
    '{8'hDD, 16'd5, 32'd0, 32'd100, MINS, MAXS, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd6},    // R6 sle
    '{8'h4D, 16'd5, 32'd0, 32'd100, 64'hF0, 64'h0F, 1'b0, 32'd101, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 no bits
    '{8'h4D, 16'd5, 32'd0, 32'd100, 64'hF1, 64'h11, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 bits
    '{8'h1E, 16'd5, 32'd0, 32'd100, 64'h1_0000_0005, 64'h2_0000_0005, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 low eq
    '{8'h1D, 16'd5, 32'd0, 32'd100, 64'h1_0000_0005, 64'h2_0000_0005, 1'b0, 32'd101, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 wide ne
    '{8'h6E, 16'd5, 32'd0, 32'd100, 64'h8000_0000, 64'd1, 1'b0, 32'd101, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 sign bit 31
    '{8'h2E, 16'd5, 32'd0, 32'd100, 64'h8000_0000, 64'd1, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 unsigned narrow
    '{8'h6D, 16'd5, 32'd0, 32'd100, 64'h8000_0000, 64'd1, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 same wide
    '{8'h15, 16'd5, 32'hFFFF_FFFF, 32'd100, ONES, 64'd0, 1'b1, 32'd106, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 imm sext
    '{8'h1D, 16'd5, 32'hFFFF_FFFF, 32'd100, ONES, 64'd0, 1'b0, 32'd101, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 reg source
    '{8'h25, 16'd5, 32'hFFFF_FFFF, 32'd100, 64'd5, 64'd0, 1'b0, 32'd101, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 imm unsigned
    '{8'h05, 16'hFFFD, 32'd0, 32'd100, 64'd0, 64'd0, 1'b1, 32'd98, 1'b0, 1'b0, 1'b0, 4'd11},     // R11 back
    '{8'h05, 16'h7FFF, 32'd0, 32'd0, 64'd0, 64'd0, 1'b1, 32'h8000, 1'b0, 1'b0, 1'b0, 4'd10},     // R10 max fwd
    '{8'h05, 16'h8000, 32'd0, 32'd10, 64'd0, 64'd0, 1'b1, 32'hFFFF_800B, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 wrap
    '{8'h85, 16'd5, 32'h1234, 32'd100, 64'd0, 64'd0, 1'b0, 32'd101, 1'b1, 1'b0, 1'b0, 4'd12},    // R12 call
    '{8'h86, 16'd5, 32'hABCD, 32'd100, 64'd0, 64'd0, 1'b0, 32'd101, 1'b1, 1'b0, 1'b0, 4'd12},    // R12 call narrow
    '{8'h95, 16'd5, 32'h77, 32'd100, 64'd0, 64'd0, 1'b0, 32'd101, 1'b0, 1'b1, 1'b0, 4'd13},      // R13 exit
    '{8'h96, 16'd5, 32'd0, 32'd100, 64'd0, 64'd0, 1'b0, 32'd101, 1'b0, 1'b0, 1'b1, 4'd14},       // R14 exit narrow
    '{8'h06, 16'd5, 32'd0, 32'd100, 64'd0, 64'd0, 1'b0, 32'd101, 1'b0, 1'b0, 1'b1, 4'd14},       // R14 always narrow
    '{8'hE5, 16'd5, 32'd0, 32'd100, 64'd0, 64'd0, 1'b0, 32'd101, 1'b0, 1'b0, 1'b1, 4'd14},       // R14 code 0xe
    '{8'h07, 16'd5, 32'd0, 32'd100, 64'd5, 64'd5, 1'b0, 32'd101, 1'b0, 1'b0, 1'b1, 4'd14}        // R14 other class
  };

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_opcode = v.op;
    in_offset = v.off;
    in_imm    = v.imm;
    in_pc     = v.pc;
    in_dst    = v.dst;
    in_src    = v.src;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    vec_t v;
    logic [31:0] exp_id;
    repeat (3) @(negedge clk);
    // R3 reset state
    check(out_valid == 1'b0, "R3 out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R3 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R3 out_valid after reset", 64'(out_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      drive(v);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      exp_id = v.cl ? v.imm : 32'd0;
      check(out_valid == 1'b1, $sformatf("R1 vec %0d valid", i), 64'(out_valid), 64'd1);
      check(out_taken == v.tk, $sformatf("R%0d vec %0d taken", v.req, i), 64'(out_taken), 64'(v.tk));
      check(out_next_pc == v.npc, $sformatf("R10 vec %0d next_pc", i), 64'(out_next_pc), 64'(v.npc));
      check(out_call == v.cl, $sformatf("R12 vec %0d call", i), 64'(out_call), 64'(v.cl));
      check(out_call_id == exp_id, $sformatf("R12 vec %0d call_id", i), 64'(out_call_id), 64'(exp_id));
      check(out_exit == v.ex, $sformatf("R13 vec %0d exit", i), 64'(out_exit), 64'(v.ex));
      check(out_illegal == v.il, $sformatf("R14 vec %0d illegal", i), 64'(out_illegal), 64'(v.il));
    end

    // R1 output slot empties when nothing new arrives
    @(negedge clk);
    check(out_valid == 1'b0, "R1 slot drains", 64'(out_valid), 64'd0);

    // R2 back-pressure: hold a taken result while consumer stalls
    out_ready = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b1, "R2 first result present", 64'(out_valid), 64'd1);
    check(in_ready == 1'b0, "R2 in_ready low while stalled", 64'(in_ready), 64'd0);
    drive(VECS[1]);
    repeat (2) @(negedge clk);
    check(out_taken == 1'b1, "R2 taken held", 64'(out_taken), 64'd1);
    check(out_next_pc == 32'd106, "R2 next_pc held", 64'(out_next_pc), 64'd106);
    // R1 releasing the consumer lets the pending instruction in
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R1 in_ready with out_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R1 second result present", 64'(out_valid), 64'd1);
    check(out_taken == 1'b0, "R4 second result taken", 64'(out_taken), 64'd0);
    check(out_next_pc == 32'd101, "R10 second result next_pc", 64'(out_next_pc), 64'd101);

    // R3 reset mid-stream clears the slot
    drive(VECS[2]);
    in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R3 reset clears result", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule